// File: doc/BRIEF.md
# Iterative Nonrestoring Unsigned Divider

This block divides one unsigned WIDTH-bit integer by another and returns a WIDTH-bit quotient and a WIDTH-bit remainder. A one-cycle start strobe accepts the operands. The block then runs one shift-and-add-or-subtract step per clock. A running partial remainder that has gone negative is not restored inside the loop. The next step adds the divisor back instead of subtracting it, and a single correction cycle after the loop makes the final remainder non-negative.

The block holds a WIDTH+1 bit signed accumulator, a shift register that starts with the dividend and ends with the quotient, and a register for the divisor. A zero divisor is caught when the operands are accepted. It raises an error flag and finishes at once, with no iteration. The quotient and remainder hold their values until the next accepted start, so the consumer can read them at any time after the done pulse.

Top module: `nrdiv_top`

## Requirements
- R1: For a nonzero divisor, the quotient equals floor(dividend / divisor) and the remainder equals dividend mod divisor, both unsigned, at the cycle where done_o is high.
- R2: For a nonzero divisor, done_o is high during the cycle that follows the (WIDTH+1)-th rising edge after the edge that sampled start_i.
- R3: busy_o is high from the edge that accepts a nonzero-divisor start until the edge that raises done_o, and busy_o is low whenever done_o is high.
- R4: done_o is high for exactly one cycle per accepted operation.
- R5: quotient_o, remainder_o and div0_o do not change while the block is idle and start_i is low.
- R6: A start_i pulse while busy_o is high is ignored: the running operation completes with its original operands and timing.
- R7: A zero divisor raises div0_o and done_o in the cycle after the accepting edge, with busy_o low. In that case quotient_o is all ones and remainder_o equals the dividend. A later accepted start with a nonzero divisor clears div0_o.
- R8: After a synchronous active-low reset, busy_o, done_o and div0_o are 0, and quotient_o and remainder_o are 0.
- R9: With WIDTH=4, dividing 8 by 3 gives quotient 2 and remainder 2.
- R10: When done_o is high and div0_o is low, the remainder is strictly less than the stored divisor and the accumulator sign bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Accept operands when idle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div0_o | output | 1 | Last accepted divisor was zero |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
The divider is run with operand pairs from a pseudo-random sequence, mixed with fixed edge pairs:
- Dividend smaller than the divisor, which separates a wrong quotient-bit rule from a correct one.
- Equal operands and a divisor of one, which expose off-by-one step counts.
- The largest dividend over the largest divisor, which stresses the accumulator sign bit.
- A zero dividend.
- Cases that leave the last partial remainder negative, which show whether the final correction cycle is present.

Starts issued mid-run and long idle gaps separate an engine that ignores a stray strobe and holds its results from one that restarts or drifts. A zero divisor, followed by a normal division, checks that the error flag is raised and then cleared.

// File: rtl/nrdiv_pkg.sv
// Shared types for the nonrestoring divider.
package nrdiv_pkg;
    // Sequencer states: waiting, iterating, final remainder correction.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_step.sv
// One nonrestoring iteration, purely combinational.
// Shifts {acc, q} left by one. Then subtracts the divisor if the incoming
// accumulator sign is 0, or adds it if the sign is 1, and writes the inverted
// new sign into the quotient LSB.
// Assumes WIDTH >= 2; the accumulator is WIDTH+1 bits, two's complement.
module nrdiv_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] q_i,
    input  logic [WIDTH-1:0] m_i,
    output logic [WIDTH:0]   acc_o,
    output logic [WIDTH-1:0] q_o
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0] shifted;
    logic [AW-1:0] m_ext;
    logic [AW-1:0] sum;

    // Shift, choose add or subtract from the old sign, set quotient bit.
    always_comb begin
        shifted = {acc_i[WIDTH-1:0], q_i[WIDTH-1]};
        m_ext   = {1'b0, m_i};
        if (acc_i[WIDTH]) begin
            sum = shifted + m_ext;
        end else begin
            sum = shifted - m_ext;
        end
        acc_o = sum;
        q_o   = {q_i[WIDTH-2:0], ~sum[WIDTH]};
    end
endmodule

// File: rtl/nrdiv_fix.sv
// Final remainder correction, combinational.
// Adds the divisor back once when the accumulator ended negative.
// Assumes the accumulator lies in [-m, m) after the loop.
module nrdiv_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] m_i,
    output logic [WIDTH:0]   acc_o
);
    // Restore a negative remainder with a single addition.
    always_comb begin
        if (acc_i[WIDTH]) begin
            acc_o = acc_i + {1'b0, m_i};
        end else begin
            acc_o = acc_i;
        end
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer for the divider.
// Accepts a start only when idle. A zero divisor completes at once with the
// error flag set. Otherwise it runs WIDTH step cycles and one correction
// cycle, then pulses done. Synchronous active-low reset.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_i,
    output logic load_o,
    output logic zload_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    nrdiv_state_e state;
    logic [CW-1:0] cnt;
    logic          last;

    // Decode control strobes from the state.
    always_comb begin
        load_o  = (state == ST_IDLE) && start_i && !zero_i;
        zload_o = (state == ST_IDLE) && start_i && zero_i;
        step_o  = (state == ST_RUN);
        fix_o   = (state == ST_FIX);
        busy_o  = (state != ST_IDLE);
        last    = (cnt == LAST);
    end

    // State, step counter, done pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load_o) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                        err_o <= 1'b0;
                    end else if (zload_o) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    state  <= ST_IDLE;
                    done_o <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: done lasts one cycle.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the last step is followed by the correction cycle.
    a_r2_fix_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && last) |=> fix_o);

    // R6: a start during a run does not disturb the step count.
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && start_i && !last) |=> (step_o && cnt == CW'($past(cnt) + 1'b1)));

    // R7: a zero divisor finishes immediately with the flag set.
    a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        zload_o |=> (done_o && err_o && !busy_o));
endmodule

// File: rtl/nrdiv_top.sv
// Iterative nonrestoring unsigned divider, top level.
// Holds the accumulator, the dividend/quotient register and the divisor,
// and applies one step or the correction each cycle as the sequencer asks.
// Assumes WIDTH >= 2. Synchronous active-low reset.
module nrdiv_top #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             div0_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    acc_q;
    logic [WIDTH-1:0] q_q;
    logic [WIDTH-1:0] m_q;
    logic [AW-1:0]    acc_step;
    logic [WIDTH-1:0] q_step;
    logic [AW-1:0]    acc_fix;
    logic load, zload, step, fix;
    logic zero;

    // Flag a zero divisor at the operand inputs.
    always_comb zero = (divisor_i == '0);

    nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .zero_i  (zero),
        .load_o  (load),
        .zload_o (zload),
        .step_o  (step),
        .fix_o   (fix),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (div0_o)
    );

    nrdiv_step #(.WIDTH(WIDTH)) u_step (
        .acc_i (acc_q),
        .q_i   (q_q),
        .m_i   (m_q),
        .acc_o (acc_step),
        .q_o   (q_step)
    );

    nrdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .acc_i (acc_q),
        .m_i   (m_q),
        .acc_o (acc_fix)
    );

    // Datapath registers: load, iterate or correct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            q_q   <= '0;
            m_q   <= '0;
        end else if (load) begin
            acc_q <= '0;
            q_q   <= dividend_i;
            m_q   <= divisor_i;
        end else if (zload) begin
            acc_q <= {1'b0, dividend_i};
            q_q   <= '1;
            m_q   <= '0;
        end else if (step) begin
            acc_q <= acc_step;
            q_q   <= q_step;
        end else if (fix) begin
            acc_q <= acc_fix;
        end
    end

    // Drive the result ports from the registers.
    always_comb begin
        quotient_o  = q_q;
        remainder_o = acc_q[WIDTH-1:0];
    end

    // R10: a finished remainder is non-negative and below the divisor.
    a_r10_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div0_o) |-> (!acc_q[WIDTH] && remainder_o < m_q));

    // R5: results hold while idle without a start.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(div0_o)));

    // R3: busy and done never overlap.
    a_r3_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/sim_nrdiv_top.sv
// Bench: a behavioural timing and value model compared on every clock.
module sim_nrdiv_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] dd = '0;
    logic [W-1:0] dv = '0;
    logic busy, done, div0;
    logic [W-1:0] quo, rem;

    logic start1 = 1'b0;
    logic [3:0] dd1 = '0;
    logic [3:0] dv1 = '0;
    logic busy1, done1, div01;
    logic [3:0] quo1, rem1;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nrdiv_top #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(dd),
        .divisor_i(dv), .busy_o(busy), .done_o(done), .div0_o(div0),
        .quotient_o(quo), .remainder_o(rem)
    );

    nrdiv_top #(.WIDTH(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start1), .dividend_i(dd1),
        .divisor_i(dv1), .busy_o(busy1), .done_o(done1), .div0_o(div01),
        .quotient_o(quo1), .remainder_o(rem1)
    );

    // Reference model state.
    logic         m_busy, m_done, m_err;
    logic [W-1:0] m_q, m_r, m_a, m_b;
    int           m_timer;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_err <= 1'b0;
            m_q <= '0; m_r <= '0; m_a <= '0; m_b <= '0; m_timer <= 0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                if (dv == '0) begin
                    m_done <= 1'b1; m_err <= 1'b1; m_q <= '1; m_r <= dd;
                end else begin
                    m_busy <= 1'b1; m_err <= 1'b0; m_a <= dd; m_b <= dv;
                    m_timer <= W + 1;
                end
            end else if (m_busy) begin
                m_timer <= m_timer - 1;
                if (m_timer == 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1;
                    m_q <= m_a / m_b; m_r <= m_a % m_b;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R3 busy", int'(busy), int'(m_busy));
            chk(done == m_done, "R2/R4 done", int'(done), int'(m_done));
            chk(div0 == m_err, "R7 div0", int'(div0), int'(m_err));
            if (!m_busy) begin
                chk(quo == m_q, m_done ? "R1 quotient" : "R5 quotient hold", int'(quo), int'(m_q));
                chk(rem == m_r, m_done ? "R1 remainder" : "R5 remainder hold", int'(rem), int'(m_r));
            end
        end
    end

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk); #1;
        start = 1'b1; dd = a; dv = b;
        @(negedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < W + 4; i++) @(negedge clk);
    endtask

    // Watchdog: a hang is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state.
        chk(busy == 1'b0 && done == 1'b0 && div0 == 1'b0, "R8 flags", int'({busy, done, div0}), 0);
        chk(quo == '0 && rem == '0, "R8 results", int'({quo, rem}), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Fixed edge pairs.
        run_div(8'd8, 8'd3);
        run_div(8'd5, 8'd9);
        run_div(8'd77, 8'd77);
        run_div(8'd200, 8'd1);
        run_div(8'd255, 8'd255);
        run_div(8'd255, 8'd2);
        run_div(8'd0, 8'd13);
        run_div(8'd254, 8'd255);

        // R7: zero divisor, then a normal division clears the flag.
        run_div(8'd99, 8'd0);
        repeat (5) @(negedge clk);
        run_div(8'd100, 8'd7);

        // R6: start strobes while busy are ignored.
        @(negedge clk); #1;
        start = 1'b1; dd = 8'd250; dv = 8'd11;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (3) @(negedge clk); #1;
        start = 1'b1; dd = 8'd3; dv = 8'd0;
        @(negedge clk); #1;
        dd = 8'd9; dv = 8'd4;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (W + 4) @(negedge clk);

        // R5: a long idle stretch with operands wiggling.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            dd = 8'(i * 37); dv = 8'(i);
        end

        // Pseudo-random pairs for R1.
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_div(lfsr[7:0], (i % 5 == 4) ? {4'b0, lfsr[11:8]} : lfsr[15:8]);
        end

        // R9: 8 / 3 with a 4-bit divider.
        @(negedge clk); #1;
        start1 = 1'b1; dd1 = 4'd8; dv1 = 4'd3;
        @(negedge clk); #1;
        start1 = 1'b0;
        for (int i = 0; i < 10 && !done1; i++) @(negedge clk);
        chk(done1 == 1'b1, "R9 done", int'(done1), 1);
        chk(quo1 == 4'd2, "R9 quotient", int'(quo1), 2);
        chk(rem1 == 4'd2, "R9 remainder", int'(rem1), 2);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule